// File: doc/BRIEF.md
# MD5 Block Digest Engine

This block runs the MD5 compression function over 512-bit message blocks, one round step at a time. The host pads the message and streams each block as sixteen 32-bit words through a valid/ready port. Inside each word the first message byte is the least significant byte. Input storage holds two blocks. The writer can fill one block while the other is being hashed, and the port stalls only when both blocks are waiting.

Each step takes two clocks. The first clock adds the accumulator word, the round constant and the selected message word. The second clock adds the logic-function output, rotates the result and adds that to the next word. A 37-bit constant table supplies the additive constant and the rotate amount for each of the 64 steps. The digest state is held in three register sets:
- a working set that the steps update;
- a chaining set that holds the previous block's result;
- an output set that stays unchanged while a block is being hashed.

A flag on the first word of a block starts a new message. Such a block begins from the standard initial values. Any other block continues from the chaining set. When step 63 has run, the working and chaining sets are added word by word. The sum replaces both the chaining set and the output set, and a one-cycle done pulse is raised.

Top module: `md5_block_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `digest_done` is 0 and `digest` is all zeros.
- R2: Bytes are packed little-endian: message byte 4w+j sits in bits [8j+7:8j] of word w of the block. Words are sent in order 0 to 15. `digest` holds {A,B,C,D} with A in bits [127:96]. Each word is the standard digest's byte group read little-endian.
- R3: A block whose word 0 arrives with `in_first`=1 starts from A=0x67452301, B=0xefcdab89, C=0x98badcfe, D=0x10325476. For a single padded block this gives the standard MD5 digest.
- R4: A block whose word 0 arrives with `in_first`=0 starts from the previous block's result, so a multi-block message yields its standard digest.
- R5: `in_first`=1 discards any earlier chain. A new message gives its standard digest whatever was hashed before it.
- R6: The port accepts 32 consecutive words into two block slots. It holds `in_ready` at 0 while both slots are full and takes no word while `in_ready` is 0. A slot is freed on the clock that the block's hashing completes.
- R7: `digest` changes only on the cycle in which `digest_done` is 1, and `digest_done` is never high for two consecutive cycles.
- R8: With the engine idle, `digest_done` is 1 in the cycle that follows the 130th rising edge after the edge that accepts a block's word 15. This is one start clock, 64 steps of two clocks each, and one fold clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Word offered on `in_word` |
| in_ready | output | 1 | Engine can take a word this cycle |
| in_word | input | 32 | Message word, little-endian byte packing |
| in_first | input | 1 | Sampled with word 0: the block starts a new message |
| digest_done | output | 1 | One-cycle pulse when a block's result is published |
| digest | output | 128 | Latest result {A,B,C,D}, held between pulses |

## Verification
The bench builds the engine with its default of two block slots. With that setting the port stalls after 32 back-to-back words, so a third block waits at the stall and the slot release can be observed within one test. It also makes both the two-block chained path and the restart of a new message over a live chain reachable with short messages. Digests are compared against known MD5 values for padded messages of one and two blocks.

// File: rtl/md5_pkg.sv
// Shared types and pure functions for the MD5 block engine.
// Assumes 32-bit words and 16-word blocks, as fixed by the algorithm.
package md5_pkg;
    localparam int BLK_WORDS = 16;
    localparam int IDX_W     = $clog2(BLK_WORDS);

    typedef logic [31:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } quad_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ADD, ST_ROT, ST_FOLD} eng_state_e;

    localparam quad_t SEED = '{a: 32'h67452301, b: 32'hefcdab89,
                               c: 32'h98badcfe, d: 32'h10325476};

    // Message word used by a step: the order depends on the round.
    function automatic logic [IDX_W-1:0] msg_index(input logic [5:0] step);
        logic [3:0] i;
        logic [3:0] r;
        i = step[3:0];
        case (step[5:4])
            2'd0:    r = i;
            2'd1:    r = (i << 2) + i + 4'd1;
            2'd2:    r = (i << 1) + i + 4'd5;
            default: r = (i << 3) - i;
        endcase
        return r;
    endfunction

    // Round logic function picked by the round number.
    function automatic word_t mix(input logic [1:0] rnd, input word_t x,
                                  input word_t y, input word_t z);
        case (rnd)
            2'd0:    return (x & y) | (~x & z);
            2'd1:    return (x & z) | (y & ~z);
            2'd2:    return x ^ y ^ z;
            default: return y ^ (x | ~z);
        endcase
    endfunction

    // Left rotate by a 5-bit amount.
    function automatic word_t rotl(input word_t v, input logic [4:0] s);
        logic [63:0] w;
        w = {v, v} << s;
        return w[63:32];
    endfunction
endpackage

// File: rtl/md5_const_rom.sv
// Per-step constant table: {32-bit additive constant, 5-bit rotate amount}.
// Assumes step is 0..63; purely combinational.
module md5_const_rom (
    input  logic [5:0]  step,
    output logic [36:0] entry
);
    logic [31:0] kval;
    logic [4:0]  sval;

    // Additive constant for the step.
    always_comb begin
        case (step)
            6'd0:  kval = 32'hd76aa478;  6'd1:  kval = 32'he8c7b756;
            6'd2:  kval = 32'h242070db;  6'd3:  kval = 32'hc1bdceee;
            6'd4:  kval = 32'hf57c0faf;  6'd5:  kval = 32'h4787c62a;
            6'd6:  kval = 32'ha8304613;  6'd7:  kval = 32'hfd469501;
            6'd8:  kval = 32'h698098d8;  6'd9:  kval = 32'h8b44f7af;
            6'd10: kval = 32'hffff5bb1;  6'd11: kval = 32'h895cd7be;
            6'd12: kval = 32'h6b901122;  6'd13: kval = 32'hfd987193;
            6'd14: kval = 32'ha679438e;  6'd15: kval = 32'h49b40821;
            6'd16: kval = 32'hf61e2562;  6'd17: kval = 32'hc040b340;
            6'd18: kval = 32'h265e5a51;  6'd19: kval = 32'he9b6c7aa;
            6'd20: kval = 32'hd62f105d;  6'd21: kval = 32'h02441453;
            6'd22: kval = 32'hd8a1e681;  6'd23: kval = 32'he7d3fbc8;
            6'd24: kval = 32'h21e1cde6;  6'd25: kval = 32'hc33707d6;
            6'd26: kval = 32'hf4d50d87;  6'd27: kval = 32'h455a14ed;
            6'd28: kval = 32'ha9e3e905;  6'd29: kval = 32'hfcefa3f8;
            6'd30: kval = 32'h676f02d9;  6'd31: kval = 32'h8d2a4c8a;
            6'd32: kval = 32'hfffa3942;  6'd33: kval = 32'h8771f681;
            6'd34: kval = 32'h6d9d6122;  6'd35: kval = 32'hfde5380c;
            6'd36: kval = 32'ha4beea44;  6'd37: kval = 32'h4bdecfa9;
            6'd38: kval = 32'hf6bb4b60;  6'd39: kval = 32'hbebfbc70;
            6'd40: kval = 32'h289b7ec6;  6'd41: kval = 32'heaa127fa;
            6'd42: kval = 32'hd4ef3085;  6'd43: kval = 32'h04881d05;
            6'd44: kval = 32'hd9d4d039;  6'd45: kval = 32'he6db99e5;
            6'd46: kval = 32'h1fa27cf8;  6'd47: kval = 32'hc4ac5665;
            6'd48: kval = 32'hf4292244;  6'd49: kval = 32'h432aff97;
            6'd50: kval = 32'hab9423a7;  6'd51: kval = 32'hfc93a039;
            6'd52: kval = 32'h655b59c3;  6'd53: kval = 32'h8f0ccc92;
            6'd54: kval = 32'hffeff47d;  6'd55: kval = 32'h85845dd1;
            6'd56: kval = 32'h6fa87e4f;  6'd57: kval = 32'hfe2ce6e0;
            6'd58: kval = 32'ha3014314;  6'd59: kval = 32'h4e0811a1;
            6'd60: kval = 32'hf7537e82;  6'd61: kval = 32'hbd3af235;
            6'd62: kval = 32'h2ad7d2bb;  default: kval = 32'heb86d391;
        endcase
    end

    // Rotate amount: repeats every four steps within a round.
    always_comb begin
        case ({step[5:4], step[1:0]})
            4'h0: sval = 5'd7;   4'h1: sval = 5'd12;
            4'h2: sval = 5'd17;  4'h3: sval = 5'd22;
            4'h4: sval = 5'd5;   4'h5: sval = 5'd9;
            4'h6: sval = 5'd14;  4'h7: sval = 5'd20;
            4'h8: sval = 5'd4;   4'h9: sval = 5'd11;
            4'hA: sval = 5'd16;  4'hB: sval = 5'd23;
            4'hC: sval = 5'd6;   4'hD: sval = 5'd10;
            4'hE: sval = 5'd15;  default: sval = 5'd21;
        endcase
    end

    assign entry = {kval, sval};
endmodule

// File: rtl/md5_word_buffer.sv
// Multi-slot block store with a valid/ready write port.
// Each slot holds one 16-word block and a "new message" flag taken with word 0.
// The writer fills slots in rotation; the reader consumes them in the same order
// and frees a slot with rd_release. Assumes rd_release only while rd_avail.
module md5_word_buffer #(
    parameter int NBUF = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    output logic                      wr_ready,
    input  logic [31:0]               wr_data,
    input  logic                      wr_first,
    output logic                      rd_avail,
    output logic                      rd_first,
    input  logic [md5_pkg::IDX_W-1:0] rd_idx,
    output logic [31:0]               rd_data,
    input  logic                      rd_release
);
    import md5_pkg::*;

    localparam int SEL_W  = (NBUF > 1) ? $clog2(NBUF) : 1;
    localparam int ADDR_W = SEL_W + IDX_W;
    localparam int MEM_N  = NBUF * BLK_WORDS;

    logic [31:0]      mem [MEM_N];
    logic [NBUF-1:0]  full;
    logic [NBUF-1:0]  newmsg;
    logic [SEL_W-1:0] wr_sel;
    logic [SEL_W-1:0] rd_sel;
    logic [IDX_W-1:0] wr_cnt;
    logic             accept;

    function automatic logic [SEL_W-1:0] next_sel(input logic [SEL_W-1:0] s);
        return (s == SEL_W'(NBUF - 1)) ? '0 : s + 1'b1;
    endfunction

    assign wr_ready = !full[wr_sel];
    assign accept   = wr_valid && wr_ready;
    assign rd_avail = full[rd_sel];
    assign rd_first = newmsg[rd_sel];
    assign rd_data  = mem[ADDR_W'({rd_sel, rd_idx})];

    // Store an accepted word in its slot.
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[ADDR_W'({wr_sel, wr_cnt})] <= wr_data;
        end
    end

    // Track fill position, slot ownership and per-slot message flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel <= '0;
            rd_sel <= '0;
            wr_cnt <= '0;
            full   <= '0;
            newmsg <= '0;
        end else begin
            if (accept) begin
                if (wr_cnt == '0) begin
                    newmsg[wr_sel] <= wr_first;
                end
                if (wr_cnt == IDX_W'(BLK_WORDS - 1)) begin
                    full[wr_sel] <= 1'b1;
                    wr_sel       <= next_sel(wr_sel);
                    wr_cnt       <= '0;
                end else begin
                    wr_cnt <= wr_cnt + 1'b1;
                end
            end
            if (rd_release) begin
                full[rd_sel] <= 1'b0;
                rd_sel       <= next_sel(rd_sel);
            end
        end
    end

    // R6: a slot is only freed while it holds a block.
    assert_release_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_release |-> full[rd_sel]);

    // R6: a stalled offer leaves the fill position untouched.
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> ($stable(wr_cnt) && $stable(wr_sel)));
endmodule

// File: rtl/md5_step_dp.sv
// Combinational step datapath.
// Clock 1 of a step forms a + k + x. Clock 2 adds the round function of
// (b,c,d) to the registered sum, rotates it and adds b.
module md5_step_dp (
    input  md5_pkg::quad_t work,
    input  logic [31:0]    x,
    input  logic [31:0]    k,
    input  logic [4:0]     s,
    input  logic [1:0]     rnd,
    input  logic [31:0]    pre,
    output logic [31:0]    pre_next,
    output logic [31:0]    b_next
);
    import md5_pkg::*;

    word_t t;

    // First clock's adders: accumulator word, constant and message word.
    always_comb begin
        pre_next = work.a + k + x;
    end

    // Second clock's adders around the rotator.
    always_comb begin
        t      = pre + mix(rnd, work.b, work.c, work.d);
        b_next = work.b + rotl(t, s);
    end
endmodule

// File: rtl/md5_round_core.sv
// Step sequencer with the working, chaining and output digest sets.
// Takes a block when one is available, runs 64 two-clock steps, then folds the
// working set into the chain, publishes it and frees the block. The output set
// changes only at the fold.
module md5_round_core (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      blk_avail,
    input  logic                      blk_first,
    output logic [md5_pkg::IDX_W-1:0] word_idx,
    input  logic [31:0]               word_in,
    output logic                      blk_release,
    output logic                      done,
    output md5_pkg::quad_t            shown
);
    import md5_pkg::*;

    eng_state_e  state;
    logic [5:0]  step;
    quad_t       work;
    quad_t       chain;
    quad_t       fold;
    word_t       pre;
    word_t       pre_next;
    word_t       b_next;
    logic [36:0] centry;

    md5_const_rom u_rom (
        .step  (step),
        .entry (centry)
    );

    md5_step_dp u_dp (
        .work     (work),
        .x        (word_in),
        .k        (centry[36:5]),
        .s        (centry[4:0]),
        .rnd      (step[5:4]),
        .pre      (pre),
        .pre_next (pre_next),
        .b_next   (b_next)
    );

    assign word_idx    = msg_index(step);
    assign blk_release = (state == ST_FOLD);

    // Sum of working and chaining sets at the end of a block.
    always_comb begin
        fold.a = work.a + chain.a;
        fold.b = work.b + chain.b;
        fold.c = work.c + chain.c;
        fold.d = work.d + chain.d;
    end

    // Sequence steps and update the three register sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
            work  <= '0;
            chain <= '0;
            shown <= '0;
            pre   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (blk_avail) begin
                        if (blk_first) begin
                            work  <= SEED;
                            chain <= SEED;
                        end else begin
                            work <= chain;
                        end
                        step  <= '0;
                        state <= ST_ADD;
                    end
                end
                ST_ADD: begin
                    pre   <= pre_next;
                    state <= ST_ROT;
                end
                ST_ROT: begin
                    work  <= '{a: work.d, b: b_next, c: work.b, d: work.c};
                    step  <= step + 1'b1;
                    state <= (step == 6'd63) ? ST_FOLD : ST_ADD;
                end
                default: begin
                    chain <= fold;
                    shown <= fold;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R7: the result pulse lasts one cycle.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the visible set holds except on the pulse cycle.
    assert_shown_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(shown));

    // R8: the slot release is followed by the result pulse.
    assert_fold_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_release |=> done);

    // R8: an idle engine always starts a block from step 0.
    assert_idle_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (step == 6'd0));
endmodule

// File: rtl/md5_block_engine.sv
// Top of the MD5 block engine: a two-slot word store feeding the step core.
// Assumes the host supplies blocks that are already padded, with in_first set
// on word 0 of each message's first block.
module md5_block_engine #(
    parameter int NBUF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [31:0]  in_word,
    input  logic         in_first,
    output logic         digest_done,
    output logic [127:0] digest
);
    import md5_pkg::*;

    logic             avail;
    logic             first;
    logic             release_blk;
    logic [IDX_W-1:0] idx;
    logic [31:0]      word;
    quad_t            shown;

    md5_word_buffer #(.NBUF(NBUF)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (in_valid),
        .wr_ready   (in_ready),
        .wr_data    (in_word),
        .wr_first   (in_first),
        .rd_avail   (avail),
        .rd_first   (first),
        .rd_idx     (idx),
        .rd_data    (word),
        .rd_release (release_blk)
    );

    md5_round_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_avail   (avail),
        .blk_first   (first),
        .word_idx    (idx),
        .word_in     (word),
        .blk_release (release_blk),
        .done        (digest_done),
        .shown       (shown)
    );

    assign digest = shown;
endmodule

// File: tb/md5_block_engine_bench.sv
// Directed bench: pads messages, streams them, compares with known digests.
module md5_block_engine_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_word = '0;
    logic         in_first = 1'b0;
    logic         digest_done;
    logic [127:0] digest;

    int errors = 0;
    int checks = 0;
    int dcount = 0;
    int cyc = 0;
    int acc_cyc = 0;
    int done_cyc = 0;
    int viol = 0;
    logic [127:0] cap = '0;
    logic [127:0] prev_out = '0;
    logic         prev_done = 1'b0;
    logic         mon_on = 1'b0;
    logic [31:0]  pw [32];
    int nb = 0;

    md5_block_engine u_md5_block_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_word     (in_word),
        .in_first    (in_first),
        .digest_done (digest_done),
        .digest      (digest)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Capture results and watch output stability away from the edge.
    always @(negedge clk) begin
        if (digest_done) begin
            dcount   = dcount + 1;
            cap      = digest;
            done_cyc = cyc;
        end
        if (mon_on) begin
            if (!digest_done && digest !== prev_out) viol = viol + 1;
            if (digest_done && prev_done) viol = viol + 1;
        end
        prev_out  = digest;
        prev_done = digest_done;
    end

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [127:0] to_words(input logic [127:0] h);
        return {bswap(h[127:96]), bswap(h[95:64]), bswap(h[63:32]), bswap(h[31:0])};
    endfunction

    // Pad a message into up to two blocks of little-endian words (R2).
    task automatic pad(input string s);
        logic [7:0]  bb [128];
        logic [63:0] bits;
        int n;
        n = s.len();
        nb = (n + 9 + 63) / 64;
        for (int i = 0; i < 128; i++) bb[i] = 8'h00;
        for (int i = 0; i < n; i++) bb[i] = s[i];
        bb[n] = 8'h80;
        bits = 64'(n) * 64'd8;
        for (int i = 0; i < 8; i++) bb[nb*64 - 8 + i] = bits[8*i +: 8];
        for (int w = 0; w < 32; w++)
            pw[w] = {bb[4*w+3], bb[4*w+2], bb[4*w+1], bb[4*w]};
    endtask

    task automatic send_word(input logic [31:0] w, input logic first);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        in_first = first;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        acc_cyc  = cyc;
        in_valid = 1'b0;
        in_first = 1'b0;
    endtask

    task automatic send_msg(input string s);
        pad(s);
        for (int b = 0; b < nb; b++)
            for (int w = 0; w < 16; w++)
                send_word(pw[b*16 + w], (b == 0) && (w == 0));
    endtask

    task automatic wait_done(input int target, input string req);
        int lim;
        lim = 0;
        while (dcount < target && lim < 3000) begin
            @(negedge clk);
            lim++;
        end
        @(negedge clk);
        chk(dcount == target, req, 128'(dcount), 128'(target));
    endtask

    task automatic run_msg(input string s, input logic [127:0] hexd, input string req);
        int start;
        start = dcount;
        send_msg(s);
        wait_done(start + nb, req);
        chk(cap == to_words(hexd), req, cap, to_words(hexd));
    endtask

    task automatic test_reset;
        chk(in_ready == 1'b1, "R1 ready", 128'(in_ready), 128'd1);
        chk(digest_done == 1'b0, "R1 done", 128'(digest_done), 128'd0);
        chk(digest == '0, "R1 digest", digest, '0);
    endtask

    // R8: count edges from the accept of word 15 to the result pulse.
    task automatic test_latency;
        int start;
        start = dcount;
        send_msg("message digest");
        wait_done(start + 1, "R8 count");
        chk(done_cyc - acc_cyc == 130, "R8 latency",
            128'(done_cyc - acc_cyc), 128'd130);
        chk(cap == to_words(128'hf96b697d7cb7938d525a2f31aaf161d0), "R8 digest",
            cap, to_words(128'hf96b697d7cb7938d525a2f31aaf161d0));
    endtask

    // R6/R5: fill both slots, observe the stall, queue a third block behind it.
    task automatic test_fill;
        int start;
        logic [127:0] held;
        start = dcount;
        held  = digest;
        send_msg("");
        send_msg("");
        chk(in_ready == 1'b0, "R6 stall after 32 words", 128'(in_ready), 128'd0);
        chk(digest == held, "R7 held while hashing", digest, held);
        send_msg("abc");
        wait_done(start + 3, "R6 three results");
        chk(cap == to_words(128'h900150983cd24fb0d6963f7d28e17f72), "R6 stalled block",
            cap, to_words(128'h900150983cd24fb0d6963f7d28e17f72));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        mon_on = 1'b1;
        run_msg("", 128'hd41d8cd98f00b204e9800998ecf8427e, "R3 empty");
        run_msg("abc", 128'h900150983cd24fb0d6963f7d28e17f72, "R2 abc");
        run_msg("The quick brown fox jumps over the lazy dog",
                128'h9e107d9d372bb6826bd81d3542a419d6, "R2 fox");
        run_msg("12345678901234567890123456789012345678901234567890123456789012345678901234567890",
                128'h57edf4a22be3c955ac49da2e2107b67a, "R4 two blocks");
        run_msg("abc", 128'h900150983cd24fb0d6963f7d28e17f72, "R5 restart");
        test_latency();
        test_fill();
        chk(viol == 0, "R7 stability", 128'(viol), 128'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule